// File: doc/BRIEF.md
# Windowed Fan Speed Error Corrector

This block watches a running fan and corrects its drive level when the fan does not follow it. At every sample tick it works out the speed the fan should reach: the stored duty value, scaled against the configured full-scale speed. It then forms the ratio of that target to the measured speed. The ratio is a fixed-point number with ten fractional bits. A sample whose ratio lies too far from unity counts as an error. Errors are counted inside a window that is fifteen samples long. Once six errors have been seen, the block issues a corrected duty value on a one-cycle strobe, and that value also replaces its stored duty.

The surrounding logic supplies a periodic tick (about two seconds in the intended use), the measured speed, the full-scale speed and writes of the duty value. After `enable` rises, the first five ticks are discarded, which gives a ten-second settling delay. Lowering `enable` stops sampling and clears all error bookkeeping. The two divisions are done by one sequential divider. While the divider is working, further ticks are ignored.

The controller has these states:

| State | Role |
|---|---|
| ST_OFF | Disabled; all counters are cleared. |
| ST_HOLD | Counts the settling ticks. |
| ST_WAIT | Idle; waits for a sample tick. |
| ST_TGT | The divider computes the target speed. |
| ST_RATIO | The divider computes the rounded ratio. |
| ST_JUDGE | Classifies the sample, updates the counters and may issue a correction. |

Its transitions are:

- ST_OFF→ST_HOLD when enabled.
- ST_HOLD→ST_WAIT on the fifth tick.
- ST_WAIT→ST_TGT on a tick with a non-zero measured speed. A tick with a zero speed stays in ST_WAIT.
- ST_TGT→ST_RATIO when the divider finishes.
- ST_RATIO→ST_JUDGE when the divider finishes.
- ST_JUDGE→ST_WAIT unconditionally.
- Any state→ST_OFF when `enable` is low.

Top module: `fsc_corrector`

## Requirements
- R1: The target speed is floor(duty × max_speed / 255). The ratio is the target × 1024 divided by the measured speed, rounded to nearest (half the divisor is added first). A sample is an error exactly when the ratio is above 1228 or below 820. Ratios of exactly 1228 and 820 are not errors.
- R2: A tick whose measured speed is 0 is never classified and never counted as an error. It still performs the window bookkeeping of R4.
- R3: The window counter advances on a tick, and an error's ratio is added to the accumulator, only when the error count held before that tick is greater than 1. The first two errors therefore contribute no ratio.
- R4: When the window counter reaches 15, the error count, the accumulator and the window counter all return to zero before that sample is classified.
- R5: When the error count reaches 6, `duty_new` becomes (stored duty × accumulator) >> 12, clamped to 255. `duty_upd` pulses high for exactly one clock, and the error count, accumulator and window counter return to zero.
- R6: A correction replaces the stored duty used for later targets. A `duty_wr` pulse loads `duty_in` into the stored duty.
- R7: After `enable` rises, the first 5 sample ticks are discarded; the sixth tick is the first sample.
- R8: While `enable` is low, ticks have no effect, no strobe is issued, and all error bookkeeping is cleared. Re-enabling restarts the settling delay of R7.
- R9: A tick that arrives while a sample is still being evaluated is ignored.
- R10: After reset, `duty_upd` is 0 and `duty_new` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller running |
| sample_tick | input | 1 | One-cycle periodic sample request |
| meas_speed | input | 16 | Measured fan speed |
| max_speed | input | 16 | Full-scale fan speed |
| duty_wr | input | 1 | Load strobe for the stored duty |
| duty_in | input | 8 | Duty value to load |
| duty_upd | output | 1 | One-cycle correction strobe |
| duty_new | output | 8 | Corrected duty value (held until the next correction) |

## Verification
The hardest condition to reach is the window expiry that wipes out a partial error count. It needs two errors, which arm the window counter, followed by a long run of in-tolerance or zero-speed samples. Errors are then resumed so that the count would have hit six if the wipe had not happened. The stimulus builds exactly that sequence, using a full-scale speed equal to the measured speed at maximum duty to give a ratio of exactly 1024 for the good samples. Tolerance edges are hit the same way: maximum duty with a measured speed of 1024 makes the ratio equal to the programmed full-scale speed.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_HOLD,
        ST_WAIT,
        ST_TGT,
        ST_RATIO,
        ST_JUDGE
    } fsc_state_e;
endpackage

// File: rtl/fsc_divider.sv
// Restoring divider: one quotient bit per clock, NUM_W clocks per division.
module fsc_divider #(
    parameter int NUM_W = 27,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int STEP_W = $clog2(NUM_W);

    logic [DEN_W:0]   rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] work_q;
    logic [STEP_W-1:0] step_q;
    logic             busy_q;
    logic             done_q;
    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   diff;
    logic             ge;

    always_comb begin
        shifted = {rem_q[DEN_W-1:0], work_q[NUM_W-1]};
        ge      = shifted >= {1'b0, den_q};
        diff    = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            work_q <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                work_q <= num;
                den_q  <= den;
                rem_q  <= '0;
                step_q <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= ge ? diff : shifted;
                work_q <= {work_q[NUM_W-2:0], ge};
                step_q <= step_q + STEP_W'(1);
                if (step_q == STEP_W'(NUM_W - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quo  = work_q;
endmodule

// File: rtl/fsc_scaler.sv
// Corrected duty = (duty * accumulated ratio) >> SHIFT, saturated to the duty range.
module fsc_scaler #(
    parameter int DUTY_W = 8,
    parameter int ACC_W  = 30,
    parameter int SHIFT  = 12
) (
    input  logic [DUTY_W-1:0] duty,
    input  logic [ACC_W-1:0]  acc,
    output logic [DUTY_W-1:0] duty_o
);
    localparam int PW = DUTY_W + ACC_W;

    logic [PW-1:0] prod;
    logic [PW-1:0] scaled;

    always_comb begin
        prod   = PW'(duty) * PW'(acc);
        scaled = prod >> SHIFT;
        if (|scaled[PW-1:DUTY_W]) duty_o = '1;
        else                      duty_o = scaled[DUTY_W-1:0];
    end
endmodule

// File: rtl/fsc_corrector.sv
module fsc_corrector
    import fsc_pkg::*;
#(
    parameter int SPD_W      = 16,
    parameter int DUTY_W     = 8,
    parameter int FRAC_W     = 10,
    parameter int TOL        = 204,
    parameter int ERR_LIMIT  = 6,
    parameter int SKIP_ERRS  = 1,
    parameter int WIN_LEN    = 15,
    parameter int HOLD_TICKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sample_tick,
    input  logic [SPD_W-1:0]  meas_speed,
    input  logic [SPD_W-1:0]  max_speed,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_in,
    output logic              duty_upd,
    output logic [DUTY_W-1:0] duty_new
);
    localparam int NUM_W    = SPD_W + FRAC_W + 1;
    localparam int ACC_W    = NUM_W + 3;
    localparam int CNT_W    = $clog2(ERR_LIMIT + 1);
    localparam int WIN_W    = $clog2(WIN_LEN + 1);
    localparam int HLD_W    = $clog2(HOLD_TICKS + 1);
    localparam int UNITY    = 1 << FRAC_W;
    localparam int DUTY_MAX = (1 << DUTY_W) - 1;

    fsc_state_e        state_q, state_d;
    logic [HLD_W-1:0]  hold_q;
    logic [CNT_W-1:0]  err_q;
    logic [WIN_W-1:0]  win_q;
    logic [ACC_W-1:0]  acc_q;
    logic [DUTY_W-1:0] duty_q;
    logic [SPD_W-1:0]  meas_q;

    logic              div_start, div_busy, div_done;
    logic [NUM_W-1:0]  div_num, div_quo;
    logic [SPD_W-1:0]  div_den;

    logic              tick_take, meas_zero;
    logic [WIN_W-1:0]  win_nx;
    logic              win_wrap;
    logic              is_err, fire;
    logic [CNT_W-1:0]  err_inc;
    logic [ACC_W-1:0]  acc_add;
    logic [DUTY_W-1:0] duty_fix;

    // Sample acceptance and window step (applied at the tick itself)
    always_comb begin
        tick_take = enable && sample_tick && (state_q == ST_WAIT);
        meas_zero = (meas_speed == '0);
        win_nx    = (err_q > CNT_W'(SKIP_ERRS)) ? win_q + WIN_W'(1) : win_q;
        win_wrap  = (win_nx == WIN_W'(WIN_LEN));
    end

    // Divider operand selection: target first, then rounded ratio
    always_comb begin
        div_start = (tick_take && !meas_zero) ||
                    (enable && state_q == ST_TGT && div_done);
        if (state_q == ST_TGT) begin
            div_num = (NUM_W'(div_quo[SPD_W-1:0]) << FRAC_W) + NUM_W'(meas_q >> 1);
            div_den = meas_q;
        end else begin
            div_num = NUM_W'(duty_q) * NUM_W'(max_speed);
            div_den = SPD_W'(DUTY_MAX);
        end
    end

    // Classification of a finished ratio
    always_comb begin
        is_err  = (div_quo > NUM_W'(UNITY + TOL)) || (div_quo < NUM_W'(UNITY - TOL));
        err_inc = err_q + CNT_W'(is_err);
        acc_add = (is_err && err_q > CNT_W'(SKIP_ERRS)) ? acc_q + ACC_W'(div_quo) : acc_q;
        fire    = (err_inc == CNT_W'(ERR_LIMIT));
    end

    fsc_divider #(.NUM_W(NUM_W), .DEN_W(SPD_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_quo)
    );

    fsc_scaler #(.DUTY_W(DUTY_W), .ACC_W(ACC_W), .SHIFT(FRAC_W + 2)) u_scale (
        .duty   (duty_q),
        .acc    (acc_add),
        .duty_o (duty_fix)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_HOLD;
                ST_HOLD:  if (sample_tick && hold_q == HLD_W'(HOLD_TICKS - 1)) state_d = ST_WAIT;
                ST_WAIT:  if (tick_take && !meas_zero) state_d = ST_TGT;
                ST_TGT:   if (div_done) state_d = ST_RATIO;
                ST_RATIO: if (div_done) state_d = ST_JUDGE;
                ST_JUDGE: state_d = ST_WAIT;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Counters, stored duty and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= '0;
            err_q    <= '0;
            win_q    <= '0;
            acc_q    <= '0;
            meas_q   <= '0;
            duty_q   <= '0;
            duty_upd <= 1'b0;
            duty_new <= '0;
        end else begin
            duty_upd <= 1'b0;
            if (!enable || state_q == ST_OFF) begin
                hold_q <= '0;
                err_q  <= '0;
                win_q  <= '0;
                acc_q  <= '0;
            end else begin
                if (state_q == ST_HOLD && sample_tick) hold_q <= hold_q + HLD_W'(1);
                if (tick_take) begin
                    meas_q <= meas_speed;
                    if (win_wrap) begin
                        err_q <= '0;
                        acc_q <= '0;
                        win_q <= '0;
                    end else begin
                        win_q <= win_nx;
                    end
                end
                if (state_q == ST_JUDGE) begin
                    if (fire) begin
                        duty_upd <= 1'b1;
                        duty_new <= duty_fix;
                        err_q    <= '0;
                        acc_q    <= '0;
                        win_q    <= '0;
                    end else begin
                        err_q <= err_inc;
                        acc_q <= acc_add;
                    end
                end
            end
            if (duty_wr)                                      duty_q <= duty_in;
            else if (enable && state_q == ST_JUDGE && fire)   duty_q <= duty_fix;
        end
    end
endmodule

// File: rtl/fsc_corrector_chk.sv
module fsc_corrector_chk
    import fsc_pkg::*;
#(
    parameter int ERR_LIMIT  = 6,
    parameter int WIN_LEN    = 15,
    parameter int HOLD_TICKS = 5,
    parameter int CNT_W      = 3,
    parameter int WIN_W      = 4,
    parameter int HLD_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             duty_upd,
    input fsc_state_e       state_q,
    input logic [CNT_W-1:0] err_q,
    input logic [WIN_W-1:0] win_q,
    input logic [HLD_W-1:0] hold_q,
    input logic             div_start,
    input logic             div_busy
);
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        duty_upd |=> !duty_upd);

    a_r5_strobe_from_judge: assert property (@(posedge clk) disable iff (!rst_n)
        duty_upd |-> $past(state_q == ST_JUDGE));

    a_r5_err_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        err_q < CNT_W'(ERR_LIMIT));

    a_r4_win_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        win_q < WIN_W'(WIN_LEN));

    a_r8_no_strobe_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !duty_upd);

    a_r7_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q <= HLD_W'(HOLD_TICKS));

    a_r9_divider_free_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> !div_busy);
endmodule

bind fsc_corrector fsc_corrector_chk #(
    .ERR_LIMIT  (ERR_LIMIT),
    .WIN_LEN    (WIN_LEN),
    .HOLD_TICKS (HOLD_TICKS),
    .CNT_W      (CNT_W),
    .WIN_W      (WIN_W),
    .HLD_W      (HLD_W)
) u_fsc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .duty_upd  (duty_upd),
    .state_q   (state_q),
    .err_q     (err_q),
    .win_q     (win_q),
    .hold_q    (hold_q),
    .div_start (div_start),
    .div_busy  (div_busy)
);

// File: tb/fsc_corrector_bench.sv
module fsc_corrector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        sample_tick = 1'b0;
    logic [15:0] meas_speed = '0;
    logic [15:0] max_speed = '0;
    logic        duty_wr = 1'b0;
    logic [7:0]  duty_in = '0;
    logic        duty_upd;
    logic [7:0]  duty_new;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    int    m_err = 0, m_win = 0, m_hold = 0, m_duty = 0;
    longint m_acc = 0;
    bit    m_en = 1'b0;
    int    exp_cnt = 0, exp_val = 0;

    // strobe monitor
    int mon_cnt = 0, mon_val = 0, mon_double = 0;
    bit mon_prev = 1'b0;

    always #5 clk = ~clk;

    fsc_corrector u_fsc_corrector (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sample_tick(sample_tick),
        .meas_speed(meas_speed), .max_speed(max_speed), .duty_wr(duty_wr),
        .duty_in(duty_in), .duty_upd(duty_upd), .duty_new(duty_new)
    );

    always @(negedge clk) begin
        if (duty_upd) begin
            mon_cnt++;
            mon_val = int'(duty_new);
            if (mon_prev) mon_double++;
        end
        mon_prev = duty_upd;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic model_clear();
        m_err = 0; m_win = 0; m_acc = 0;
    endtask

    task automatic model_tick(input int meas, input int maxs);
        longint tgt, r, v;
        if (!m_en) return;
        if (m_hold < 5) begin m_hold++; return; end
        if (m_err > 1) m_win++;
        if (m_win == 15) model_clear();
        if (meas == 0) return;
        tgt = longint'(m_duty) * maxs / 255;
        r = (tgt * 1024 + meas / 2) / meas;
        if (r > 1228 || r < 820) begin
            if (m_err > 1) m_acc += r;
            m_err++;
        end
        if (m_err == 6) begin
            v = (longint'(m_duty) * m_acc) >> 12;
            if (v > 255) v = 255;
            exp_cnt++;
            exp_val = int'(v);
            m_duty = int'(v);
            model_clear();
        end
    endtask

    task automatic pulse(input int meas, input int maxs);
        @(negedge clk);
        meas_speed = 16'(meas); max_speed = 16'(maxs); sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic do_tick(input int meas, input int maxs, input string req);
        pulse(meas, maxs);
        model_tick(meas, maxs);
        repeat (100) @(negedge clk);
        check(mon_cnt == exp_cnt, req, mon_cnt, exp_cnt);
        check(int'(duty_new) == exp_val, req, int'(duty_new), exp_val);
    endtask

    task automatic set_duty(input int v);
        @(negedge clk);
        duty_in = 8'(v); duty_wr = 1'b1;
        @(negedge clk);
        duty_wr = 1'b0;
        m_duty = v;
    endtask

    task automatic restart();
        @(negedge clk); enable = 1'b0; m_en = 1'b0; model_clear();
        repeat (3) @(negedge clk);
        enable = 1'b1; m_en = 1'b1; m_hold = 0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5; i++) do_tick(1000, 4000, "R7");
    endtask

    task automatic t_reset();
        check(duty_upd == 1'b0, "R10", int'(duty_upd), 0);
        check(duty_new == 8'd0, "R10", int'(duty_new), 0);
    endtask

    // R7: settling ticks ignored even with bad speeds; R5 clamp at 255
    task automatic t_holdoff();
        set_duty(128);
        @(negedge clk); enable = 1'b1; m_en = 1'b1; m_hold = 0;
        for (int i = 0; i < 5; i++) do_tick(1000, 4000, "R7");
        for (int i = 0; i < 5; i++) do_tick(1000, 4000, "R7");
        do_tick(1000, 4000, "R5");
        check(mon_cnt == 1, "R5", mon_cnt, 1);
        check(int'(duty_new) == 255, "R5", int'(duty_new), 255);
    endtask

    // R6/R3: stored duty replaced; first two errors carry no ratio
    task automatic t_update();
        for (int i = 0; i < 6; i++) do_tick(6000, 4000, "R6");
        set_duty(200);
        do_tick(300, 4000, "R3");
        do_tick(300, 4000, "R3");
        for (int i = 0; i < 4; i++) do_tick(6000, 4000, "R3");
    endtask

    // R1: tolerance edges, ratio equals max_speed at duty 255, meas 1024
    task automatic t_boundary();
        restart();
        set_duty(255);
        for (int i = 0; i < 6; i++) do_tick(1024, 1228, "R1");
        for (int i = 0; i < 6; i++) do_tick(1024, 1229, "R1");
        set_duty(255);
        for (int i = 0; i < 6; i++) do_tick(1024, 820, "R1");
        for (int i = 0; i < 6; i++) do_tick(1024, 819, "R1");
    endtask

    // R2: zero speed never an error but still ages the window
    task automatic t_zero();
        restart();
        set_duty(100);
        for (int i = 0; i < 5; i++) do_tick(6000, 4000, "R2");
        for (int i = 0; i < 3; i++) do_tick(0, 4000, "R2");
        do_tick(6000, 4000, "R2");
        restart();
        for (int i = 0; i < 2; i++) do_tick(6000, 4000, "R2");
        for (int i = 0; i < 13; i++) do_tick(0, 4000, "R2");
        for (int i = 0; i < 4; i++) do_tick(6000, 4000, "R2");
    endtask

    // R4: window expiry wipes a partial error count
    task automatic t_window();
        restart();
        set_duty(255);
        for (int i = 0; i < 2; i++) do_tick(6000, 4000, "R4");
        for (int i = 0; i < 13; i++) do_tick(1024, 1024, "R4");
        for (int i = 0; i < 4; i++) do_tick(6000, 4000, "R4");
        for (int i = 0; i < 4; i++) do_tick(6000, 4000, "R4");
    endtask

    // R9: a tick during evaluation is dropped
    task automatic t_busy();
        restart();
        set_duty(150);
        for (int i = 0; i < 3; i++) begin
            pulse(6000, 4000);
            model_tick(6000, 4000);
            repeat (5) @(negedge clk);
            pulse(6000, 4000);
            repeat (100) @(negedge clk);
            check(mon_cnt == exp_cnt, "R9", mon_cnt, exp_cnt);
        end
        for (int i = 0; i < 3; i++) do_tick(6000, 4000, "R9");
    endtask

    // R8: disabled ticks ignored, bookkeeping cleared, settling restarts
    task automatic t_disable();
        restart();
        set_duty(90);
        for (int i = 0; i < 5; i++) do_tick(6000, 4000, "R8");
        @(negedge clk); enable = 1'b0; m_en = 1'b0; model_clear();
        for (int i = 0; i < 3; i++) do_tick(6000, 4000, "R8");
        @(negedge clk); enable = 1'b1; m_en = 1'b1; m_hold = 0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5; i++) do_tick(6000, 4000, "R8");
        for (int i = 0; i < 6; i++) do_tick(6000, 4000, "R8");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_holdoff();
        t_update();
        t_boundary();
        t_zero();
        t_window();
        t_busy();
        t_disable();
        check(mon_double == 0, "R5", mon_double, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule